// File: doc/BRIEF.md
# Protected Register Bank Write Unlock Sequencer

This block sits behind a serial-bus byte decoder and decides whether a write burst may reach a bank of nonvolatile clock and control registers. The decoder hands it one event per cycle: a start condition, a stop condition, a completed slave byte, a register address byte, or a data byte together with the number of bits actually clocked for it. The block keeps two volatile latches. The first is a write-enable latch, and the second is a register-write-enable latch that also requires the first. A burst to the protected bank is only let through once the host has armed both latches with a fixed pair of status-register writes.

Accepted data bytes are placed on a staging port, one per cycle, with their bank address. On a clean stop the block pulses a commit strobe and starts a busy timer that models the nonvolatile programming time in units of an external tick. When that timer expires, the register-write-enable latch clears, so every change to the bank needs a fresh unlock. A transfer that ends badly pulses a discard strobe instead, and it leaves the latches as they were. Bursts longer than the page limit either wrap inside the page or drop the excess bytes. A parameter selects which.

Top module: `ccr_write_guard`

## Requirements
- R1: After reset, both latches and busy are low, and no staging, commit or discard strobe is active.
- R2: A write frame (slave byte DEh, register address SR_ADDR = 3Fh, exactly one data byte of value 02h, then stop) sets the write-enable latch, visible on the cycle after the stop event.
- R3: A one-byte status write of 06h sets both latches only when the write-enable latch is already set. Any status value other than 00h, 02h or 06h, and 06h with the write-enable latch clear, leaves both latches unchanged. The register-write-enable latch is never high while the write-enable latch is low.
- R4: A one-byte status write of 00h clears both latches.
- R5: With the register-write-enable latch set and busy low, each complete data byte of a write frame whose base address is below BANK_SIZE (20) is staged at base plus its index. Bytes whose address reaches BANK_SIZE or more are not staged. A clean stop after at least one staged byte pulses commit.
- R6: A bank write frame arriving while the register-write-enable latch is clear stages nothing, does not commit, and leaves busy low.
- R7: Commit starts busy, which stays high for exactly NV_TICKS ticks. The register-write-enable latch clears on the edge where busy falls, and the write-enable latch is kept.
- R8: A write frame with a data byte of bit count other than 8, or one cut short by a new start before its stop, pulses discard if anything was staged, never commits, leaves the register-write-enable latch set, and has no effect when it targets the status register.
- R9: Frames whose slave byte is not DEh (reads) do not change either latch.
- R10: In drop mode (WRAP_BURST = 0), bytes after the MAX_BURST-th (8th) in one frame are not staged. In wrap mode, byte k is staged at base + (k mod MAX_BURST).
- R11: While busy is high, no data byte is staged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_valid | input | 1 | An event is presented this cycle |
| ev_kind | input | 3 | Event code: 0 start, 1 stop, 2 slave byte, 3 register address, 4 data byte |
| ev_byte | input | 8 | Byte carried by the slave, address or data event |
| ev_bits | input | 4 | Bits clocked for a data byte (8 when complete) |
| nv_tick | input | 1 | Timebase tick for the programming timer |
| wel | output | 1 | Write-enable latch |
| rwel | output | 1 | Register-write-enable latch |
| busy | output | 1 | Nonvolatile programming in progress |
| stg_we | output | 1 | Staging write strobe |
| stg_addr | output | clog2(BANK_SIZE) | Staged bank address |
| stg_data | output | 8 | Staged data byte |
| stg_commit | output | 1 | Burst committed, programming starts |
| stg_discard | output | 1 | Staged burst abandoned |

## Verification
The bench builds two copies of the block side by side on the same event stream: one with WRAP_BURST = 0 and one with WRAP_BURST = 1, both with NV_TICKS = 6 and the default 20-entry bank and 8-byte page. Sharing the stimulus puts the drop and the wrap behaviour of an over-long burst on the same frame, so the two can be compared directly. The short timer keeps the busy window small enough to fit a second write inside it and to count its ticks exactly. Bases near the top of the bank push bursts past the last defined address.

// File: rtl/ccr_guard_pkg.sv
package ccr_guard_pkg;

   typedef enum logic [2:0] {
      EV_START  = 3'd0,
      EV_STOP   = 3'd1,
      EV_SLAVE  = 3'd2,
      EV_REGADR = 3'd3,
      EV_DATA   = 3'd4
   } ev_kind_e;

   typedef enum logic [2:0] {
      FR_IDLE,
      FR_SLAVE,
      FR_ADDR,
      FR_DATA,
      FR_SKIP
   } fr_state_e;

   localparam logic [7:0] SR_CLEAR = 8'h00;
   localparam logic [7:0] SR_ARM1  = 8'h02;
   localparam logic [7:0] SR_ARM2  = 8'h06;

endpackage

// File: rtl/ccrg_frame.sv
module ccrg_frame
   import ccr_guard_pkg::*;
#(
   parameter int         CW       = 3,
   parameter logic [7:0] SLAVE_WR = 8'hDE
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ev_valid,
   input  logic [2:0]    ev_kind,
   input  logic [7:0]    ev_byte,
   input  logic [3:0]    ev_bits,
   output logic          data_go,
   output logic [CW-1:0] data_idx,
   output logic          data_over,
   output logic [7:0]    base,
   output logic          close_ok,
   output logic          close_abort,
   output logic          single,
   output logic [7:0]    last_byte
);

   fr_state_e     st;
   ev_kind_e      kind;
   logic          bad;
   logic          over;
   logic          any;
   logic [CW-1:0] cnt;
   logic          in_wr;

   assign kind  = ev_kind_e'(ev_kind);
   assign in_wr = (st == FR_ADDR) || (st == FR_DATA);

   assign data_go     = ev_valid && (kind == EV_DATA) && (st == FR_DATA)
                        && (ev_bits == 4'd8) && !bad;
   assign close_ok    = ev_valid && (kind == EV_STOP) && in_wr && !bad;
   assign close_abort = ev_valid && in_wr
                        && (((kind == EV_STOP) && bad) || (kind == EV_START));
   assign single      = any && !over && (cnt == CW'(1));
   assign data_idx    = cnt;
   assign data_over   = over;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= FR_IDLE;
         bad       <= 1'b0;
         over      <= 1'b0;
         any       <= 1'b0;
         cnt       <= '0;
         base      <= '0;
         last_byte <= '0;
      end else if (ev_valid) begin
         case (kind)
            EV_START: begin
               st   <= FR_SLAVE;
               bad  <= 1'b0;
               over <= 1'b0;
               any  <= 1'b0;
               cnt  <= '0;
            end
            EV_STOP: st <= FR_IDLE;
            EV_SLAVE: begin
               if (st == FR_SLAVE)
                  st <= (ev_byte == SLAVE_WR) ? FR_ADDR : FR_SKIP;
               else if (in_wr)
                  bad <= 1'b1;
            end
            EV_REGADR: begin
               if (st == FR_ADDR) begin
                  base <= ev_byte;
                  st   <= FR_DATA;
               end else if (st == FR_DATA) begin
                  bad <= 1'b1;
               end
            end
            EV_DATA: begin
               if (data_go) begin
                  cnt       <= cnt + 1'b1;
                  if (&cnt) over <= 1'b1;
                  last_byte <= ev_byte;
                  any       <= 1'b1;
               end else if (in_wr) begin
                  bad <= 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   // R8: a frame never ends both cleanly and aborted
   p_close_unique_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(close_ok && close_abort));

endmodule

// File: rtl/ccrg_burst.sv
module ccrg_burst #(
   parameter int BANK_SIZE  = 20,
   parameter int WRAP_BURST = 0,
   parameter int CW         = 3,
   parameter int AW         = 5
) (
   input  logic [7:0]    base,
   input  logic [CW-1:0] idx,
   input  logic          over,
   output logic          hit,
   output logic [AW-1:0] addr
);

   logic [8:0] sum;
   logic       in_win;

   // page index wraps naturally in CW bits; drop mode masks once it wrapped
   assign sum    = {1'b0, base} + 9'(idx);
   assign in_win = (WRAP_BURST != 0) ? 1'b1 : !over;
   assign hit    = in_win && (sum < 9'(BANK_SIZE));
   assign addr   = sum[AW-1:0];

endmodule

// File: rtl/ccrg_timer.sv
module ccrg_timer #(
   parameter int NV_TICKS = 10,
   parameter int TW       = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic tick,
   output logic busy,
   output logic done
);

   logic [TW-1:0] cnt;

   assign busy = (cnt != '0);
   assign done = busy && tick && (cnt == TW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (start)
         cnt <= TW'(NV_TICKS);
      else if (busy && tick)
         cnt <= cnt - 1'b1;
   end

   // R7: the countdown never exceeds its load value
   p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= TW'(NV_TICKS));

   // R7: the last tick ends the busy window
   p_done_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done && !start |=> !busy);

endmodule

// File: rtl/ccr_write_guard.sv
module ccr_write_guard
   import ccr_guard_pkg::*;
#(
   parameter int         BANK_SIZE  = 20,
   parameter logic [7:0] SR_ADDR    = 8'h3F,
   parameter int         MAX_BURST  = 8,
   parameter int         WRAP_BURST = 0,
   parameter int         NV_TICKS   = 10,
   parameter logic [7:0] SLAVE_WR   = 8'hDE
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         ev_valid,
   input  logic [2:0]                   ev_kind,
   input  logic [7:0]                   ev_byte,
   input  logic [3:0]                   ev_bits,
   input  logic                         nv_tick,
   output logic                         wel,
   output logic                         rwel,
   output logic                         busy,
   output logic                         stg_we,
   output logic [$clog2(BANK_SIZE)-1:0] stg_addr,
   output logic [7:0]                   stg_data,
   output logic                         stg_commit,
   output logic                         stg_discard
);

   localparam int AW = $clog2(BANK_SIZE);
   localparam int CW = $clog2(MAX_BURST);
   localparam int TW = $clog2(NV_TICKS + 1);

   generate
      if (MAX_BURST < 2 || (MAX_BURST & (MAX_BURST - 1)) != 0) begin : g_bad_burst
         $error("MAX_BURST must be a power of two of at least 2");
      end
      if (BANK_SIZE < 2 || BANK_SIZE > 256) begin : g_bad_bank
         $error("BANK_SIZE must lie in 2..256");
      end
      if (int'(SR_ADDR) < BANK_SIZE) begin : g_bad_sr
         $error("SR_ADDR must lie outside the protected bank");
      end
      if (NV_TICKS < 1) begin : g_bad_ticks
         $error("NV_TICKS must be at least 1");
      end
   endgenerate

   logic          f_go, f_over, f_ok, f_abort, f_single;
   logic [CW-1:0] f_idx;
   logic [7:0]    f_base, f_last;
   logic          b_hit;
   logic [AW-1:0] b_addr;
   logic          t_start, t_done;
   logic          staged;
   logic          accept;
   logic          sr_write;

   ccrg_frame #(.CW(CW), .SLAVE_WR(SLAVE_WR)) u_frame (
      .clk(clk), .rst_n(rst_n),
      .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_byte(ev_byte), .ev_bits(ev_bits),
      .data_go(f_go), .data_idx(f_idx), .data_over(f_over), .base(f_base),
      .close_ok(f_ok), .close_abort(f_abort), .single(f_single), .last_byte(f_last)
   );

   ccrg_burst #(.BANK_SIZE(BANK_SIZE), .WRAP_BURST(WRAP_BURST), .CW(CW), .AW(AW)) u_burst (
      .base(f_base), .idx(f_idx), .over(f_over), .hit(b_hit), .addr(b_addr)
   );

   ccrg_timer #(.NV_TICKS(NV_TICKS), .TW(TW)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(t_start), .tick(nv_tick),
      .busy(busy), .done(t_done)
   );

   assign accept   = f_go && b_hit && rwel && !busy;
   assign t_start  = f_ok && staged;
   assign sr_write = f_ok && (f_base == SR_ADDR) && f_single;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_we      <= 1'b0;
         stg_addr    <= '0;
         stg_data    <= '0;
         stg_commit  <= 1'b0;
         stg_discard <= 1'b0;
         staged      <= 1'b0;
      end else begin
         stg_we      <= accept;
         stg_commit  <= f_ok && staged;
         stg_discard <= f_abort && staged;
         if (accept) begin
            stg_addr <= b_addr;
            stg_data <= ev_byte;
         end
         if (f_ok || f_abort)
            staged <= 1'b0;
         else if (accept)
            staged <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel  <= 1'b0;
         rwel <= 1'b0;
      end else begin
         if (t_done)
            rwel <= 1'b0;
         if (sr_write) begin
            case (f_last)
               SR_CLEAR: begin
                  wel  <= 1'b0;
                  rwel <= 1'b0;
               end
               SR_ARM1: wel <= 1'b1;
               SR_ARM2: begin
                  if (wel) rwel <= 1'b1;
               end
               default: ;
            endcase
         end
      end
   end

   // R6 and R11: staging only while unlocked and idle
   p_stage_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
      stg_we |-> rwel && !busy);

   // R3: second latch never stands alone
   p_rwel_needs_wel_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rwel |-> wel);

   // R7: busy starts only together with a commit
   p_busy_from_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> stg_commit);

   // R7: end of programming drops the second latch
   p_rwel_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !rwel);

   // R8: one outcome per frame
   p_one_outcome_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(stg_commit && stg_discard));

   // R5: staged addresses stay inside the bank
   p_addr_in_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
      stg_we |-> int'(stg_addr) < BANK_SIZE);

endmodule

// File: tb/test_ccr_write_guard.sv
module test_ccr_write_guard;

   localparam int NVT = 6;
   localparam int BS  = 20;
   localparam int MB  = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ev_valid = 1'b0;
   logic [2:0] ev_kind = 3'd0;
   logic [7:0] ev_byte = 8'd0;
   logic [3:0] ev_bits = 4'd0;
   logic       nv_tick = 1'b0;

   logic       wel_a, rwel_a, busy_a, we_a, com_a, dis_a;
   logic [4:0] addr_a;
   logic [7:0] data_a;
   logic       wel_b, rwel_b, busy_b, we_b, com_b, dis_b;
   logic [4:0] addr_b;
   logic [7:0] data_b;

   ccr_write_guard #(.NV_TICKS(NVT), .WRAP_BURST(0)) i_ccr_write_guard (
      .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
      .ev_byte(ev_byte), .ev_bits(ev_bits), .nv_tick(nv_tick),
      .wel(wel_a), .rwel(rwel_a), .busy(busy_a), .stg_we(we_a),
      .stg_addr(addr_a), .stg_data(data_a), .stg_commit(com_a), .stg_discard(dis_a)
   );

   ccr_write_guard #(.NV_TICKS(NVT), .WRAP_BURST(1)) i_ccr_write_guard_wrap (
      .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
      .ev_byte(ev_byte), .ev_bits(ev_bits), .nv_tick(nv_tick),
      .wel(wel_b), .rwel(rwel_b), .busy(busy_b), .stg_we(we_b),
      .stg_addr(addr_b), .stg_data(data_b), .stg_commit(com_b), .stg_discard(dis_b)
   );

   always #4 clk = ~clk;

   int checks = 0;
   int fails = 0;
   bit finished = 0;
   int nwe_a = 0, nwe_b = 0, ncom = 0, ndis = 0, ntb = 0;
   logic [7:0] mem_a [32];
   logic [7:0] mem_b [32];
   logic [7:0] exp_a [32];
   logic [7:0] exp_b [32];
   int ea = 0, eb = 0;
   logic [7:0] dbuf [16];
   bit m_wel = 0, m_rwel = 0;
   int tdiv = 0;

   always @(negedge clk) begin
      tdiv = (tdiv == 2) ? 0 : tdiv + 1;
      nv_tick = (tdiv == 0);
   end

   always @(posedge clk) begin
      if (we_a) begin mem_a[addr_a] = data_a; nwe_a++; end
      if (we_b) begin mem_b[addr_b] = data_b; nwe_b++; end
      if (com_a) ncom++;
      if (dis_a) ndis++;
      if (nv_tick && busy_a) ntb++;
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic send(input logic [2:0] k, input logic [7:0] b, input logic [3:0] n);
      ev_valid = 1'b1; ev_kind = k; ev_byte = b; ev_bits = n;
      @(negedge clk);
      ev_valid = 1'b0;
   endtask

   // abort: 0 none, 1 short last byte, 2 restart in place of stop
   task automatic frame(input logic [7:0] slv, input logic [7:0] adr, input int n, input int abort);
      send(3'd0, 8'h00, 4'd0);
      send(3'd2, slv, 4'd8);
      send(3'd3, adr, 4'd8);
      for (int k = 0; k < n; k++)
         send(3'd4, dbuf[k], (abort == 1 && k == n - 1) ? 4'd7 : 4'd8);
      if (abort == 2) send(3'd0, 8'h00, 4'd0);
      send(3'd1, 8'h00, 4'd0);
      @(negedge clk);
      @(negedge clk);
   endtask

   function automatic void model_sr(input logic [7:0] v);
      if (v == 8'h00) begin m_wel = 0; m_rwel = 0; end
      else if (v == 8'h02) m_wel = 1;
      else if (v == 8'h06 && m_wel) m_rwel = 1;
   endfunction

   task automatic sr(input logic [7:0] v);
      dbuf[0] = v;
      frame(8'hDE, 8'h3F, 1, 0);
      model_sr(v);
   endtask

   task automatic rd_frame();
      send(3'd0, 8'h00, 4'd0);
      send(3'd2, 8'hDF, 4'd8);
      send(3'd4, 8'h02, 4'd8);
      send(3'd4, 8'h06, 4'd8);
      send(3'd1, 8'h00, 4'd0);
      @(negedge clk);
   endtask

   function automatic void exp_burst(input int base, input int n);
      for (int k = 0; k < n; k++) begin
         if (k < MB && base + k < BS) begin exp_a[base + k] = dbuf[k]; ea++; end
         if (base + (k % MB) < BS) begin exp_b[base + (k % MB)] = dbuf[k]; eb++; end
      end
   endfunction

   task automatic cmp_mem(input string tag);
      int bad = 0;
      for (int i = 0; i < BS; i++) begin
         if (mem_a[i] !== exp_a[i]) bad++;
         if (mem_b[i] !== exp_b[i]) bad++;
      end
      chk(tag, bad, 0);
   endtask

   task automatic wait_idle();
      int t = 0;
      while (busy_a && t < 2000) begin @(negedge clk); t++; end
      chk("R7 busy ends", int'(busy_a), 0);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog: actual 0 expected 1");
         summary();
         $finish;
      end
   end

   initial begin
      int c0, w0, t0, d0, base, n, op;
      logic [7:0] v;
      for (int i = 0; i < 32; i++) begin
         mem_a[i] = 8'h00; mem_b[i] = 8'h00; exp_a[i] = 8'h00; exp_b[i] = 8'h00;
      end
      void'($urandom(32'd77));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 wel", int'(wel_a), 0);
      chk("R1 rwel", int'(rwel_a), 0);
      chk("R1 busy", int'(busy_a), 0);
      chk("R1 strobes", int'(we_a | com_a | dis_a), 0);

      // R3 second step without first
      sr(8'h06);
      chk("R3 06 alone rwel", int'(rwel_a), 0);
      chk("R3 06 alone wel", int'(wel_a), 0);
      // R2 first step
      sr(8'h02);
      chk("R2 wel set", int'(wel_a), 1);
      chk("R2 rwel clear", int'(rwel_a), 0);
      // R9 read between steps
      rd_frame();
      chk("R9 wel kept", int'(wel_a), 1);
      // R3 other value ignored
      sr(8'h04);
      chk("R3 04 ignored", int'(rwel_a), 0);
      sr(8'h06);
      chk("R3 both set rwel", int'(rwel_a), 1);
      chk("R3 both set wel", int'(wel_a), 1);
      // R4 clear
      sr(8'h00);
      chk("R4 wel clear", int'(wel_a), 0);
      chk("R4 rwel clear", int'(rwel_a), 0);

      // R6 locked bank write
      w0 = nwe_a; c0 = ncom;
      dbuf[0] = 8'h11; dbuf[1] = 8'h22; dbuf[2] = 8'h33;
      frame(8'hDE, 8'd2, 3, 0);
      chk("R6 nothing staged", nwe_a - w0, 0);
      chk("R6 no commit", ncom - c0, 0);
      chk("R6 not busy", int'(busy_a), 0);

      // R5 unlocked bank write
      sr(8'h02); sr(8'h06);
      w0 = nwe_a; c0 = ncom; t0 = ntb;
      dbuf[0] = 8'hA1; dbuf[1] = 8'hA2; dbuf[2] = 8'hA3;
      frame(8'hDE, 8'd4, 3, 0);
      exp_burst(4, 3);
      chk("R5 staged count", nwe_a - w0, 3);
      cmp_mem("R5 staged data");
      chk("R5 commit", ncom - c0, 1);
      chk("R7 busy after commit", int'(busy_a), 1);
      chk("R7 rwel held while busy", int'(rwel_a), 1);
      // R11 write during busy
      w0 = nwe_a;
      dbuf[0] = 8'h5A;
      frame(8'hDE, 8'd0, 1, 0);
      chk("R11 blocked while busy", nwe_a - w0, 0);
      wait_idle();
      chk("R7 tick count", ntb - t0, NVT);
      chk("R7 rwel cleared", int'(rwel_a), 0);
      chk("R7 wel kept", int'(wel_a), 1);
      m_rwel = 0;

      // R8 aborts
      sr(8'h02); sr(8'h06);
      w0 = nwe_a; c0 = ncom; d0 = ndis;
      dbuf[0] = 8'h77; dbuf[1] = 8'h78;
      frame(8'hDE, 8'd0, 2, 1);
      chk("R8 short byte discard", ndis - d0, 1);
      chk("R8 short byte no commit", ncom - c0, 0);
      chk("R8 rwel survives", int'(rwel_a), 1);
      chk("R8 not busy", int'(busy_a), 0);
      for (int i = 0; i < 32; i++) begin exp_a[i] = mem_a[i]; exp_b[i] = mem_b[i]; end
      d0 = ndis;
      frame(8'hDE, 8'd6, 2, 2);
      chk("R8 restart discard", ndis - d0, 1);
      chk("R8 restart rwel survives", int'(rwel_a), 1);
      for (int i = 0; i < 32; i++) begin exp_a[i] = mem_a[i]; exp_b[i] = mem_b[i]; end
      dbuf[0] = 8'h00;
      frame(8'hDE, 8'h3F, 1, 1);
      chk("R8 aborted status write", int'(wel_a & rwel_a), 1);

      // R5 undefined addresses
      w0 = nwe_a; c0 = ncom;
      frame(8'hDE, 8'd25, 2, 0);
      chk("R5 undefined ignored", nwe_a - w0, 0);
      chk("R5 undefined no commit", ncom - c0, 0);

      // R10 over-long burst, drop vs wrap
      w0 = nwe_a; c0 = nwe_b;
      for (int k = 0; k < 11; k++) dbuf[k] = 8'hC0 + 8'(k);
      frame(8'hDE, 8'd2, 11, 0);
      exp_burst(2, 11);
      chk("R10 drop count", nwe_a - w0, 8);
      chk("R10 wrap count", nwe_b - c0, 11);
      cmp_mem("R10 drop and wrap data");
      wait_idle();
      m_rwel = 0;

      // constrained random mix
      for (int it = 0; it < 40; it++) begin
         op = $urandom_range(0, 3);
         if (op == 0) begin
            case ($urandom_range(0, 4))
               0: v = 8'h00; 1: v = 8'h02; 2: v = 8'h06; 3: v = 8'h0E;
               default: v = 8'($urandom);
            endcase
            sr(v);
            chk("R3 random status wel", int'(wel_a), int'(m_wel));
            chk("R3 random status rwel", int'(rwel_a), int'(m_rwel));
         end else if (op == 1) begin
            rd_frame();
            chk("R9 random read", int'({wel_a, rwel_a}), int'({m_wel, m_rwel}));
         end else begin
            sr(8'h02); sr(8'h06);
            base = $urandom_range(0, 23);
            n = $urandom_range(1, 12);
            for (int k = 0; k < n; k++) dbuf[k] = 8'($urandom);
            w0 = nwe_a; c0 = nwe_b; ea = 0; eb = 0; t0 = ncom; d0 = ndis;
            if (op == 3) begin
               for (int i = 0; i < 32; i++) begin exp_a[i] = mem_a[i]; exp_b[i] = mem_b[i]; end
               frame(8'hDE, 8'(base), n, 1);
               chk("R8 random abort commit", ncom - t0, 0);
               chk("R8 random abort rwel", int'(rwel_a), 1);
               for (int i = 0; i < 32; i++) begin exp_a[i] = mem_a[i]; exp_b[i] = mem_b[i]; end
            end else begin
               frame(8'hDE, 8'(base), n, 0);
               exp_burst(base, n);
               chk("R10 random drop count", nwe_a - w0, ea);
               chk("R10 random wrap count", nwe_b - c0, eb);
               cmp_mem("R5 random data");
               chk("R5 random commit", ncom - t0, (ea > 0) ? 1 : 0);
               wait_idle();
               if (ea > 0) m_rwel = 0;
               chk("R7 random rwel", int'(rwel_a), int'(m_rwel));
            end
         end
      end

      finished = 1;
      summary();
      $finish;
   end

endmodule